// File: doc/BRIEF.md
# Ordered Store Queue with Load Forwarding

This block sits between one hardware thread's load/store port and a shared memory port and gives that thread total-store-order behaviour. Stores are accepted into a private first-in first-out queue and written to memory one by one, oldest first. Loads are not queued. A load first searches the buffered stores. If it finds one or more entries for its address it answers from the youngest of them. Otherwise it reads memory at once, so it may overtake older stores to other addresses.

Two requests order the thread against memory. A barrier (fence) waits until the queue is empty. A locked swap waits until the queue is empty, then performs a read and a write to memory while holding a lock signal, and returns the old value. Memory accepts requests with a valid/ready handshake and returns read data (and only read data) on a response strobe, in order, at least one cycle after acceptance.

Top module: `tso_store_buffer`

## Requirements
- R1: Stores reach memory as writes in exactly the order the thread issued them. An entry leaves the queue only on the cycle its write is accepted (m_req_valid and m_req_ready both high).
- R2: A load (t_op = 0) whose address matches a queued store is answered with t_rvalid one cycle after acceptance, carrying the buffered data, and no memory read is issued for it.
- R3: When several queued stores share the load address, the data comes from the most recently issued of them.
- R4: A load with no match issues one memory read (m_req_write low) at its own address. Its data is returned on t_rdata with t_rvalid one cycle after m_rsp_valid.
- R5: While the queue holds DEPTH entries, a store request (t_op = 1) sees t_ready low until an entry has been written to memory.
- R6: A load that matches a queued store is accepted and answered even while the queue is full.
- R7: A fence (t_op = 3) is accepted only when the queue is empty. It causes no memory access and no response.
- R8: A locked swap (t_op = 2) is accepted only when the queue is empty. It then issues a read and a write to its address with m_lock high from the read request until the write is accepted, and returns the value read.
- R9: Once m_req_valid is high and not accepted, it stays high with address, data and write flag unchanged on the next cycle.
- R10: During reset, t_rvalid, m_req_valid and m_lock are low.
- R11: A load with no match can issue its memory read while older stores to other addresses are still queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| t_valid | input | 1 | Thread request valid |
| t_ready | output | 1 | Request accepted this cycle when valid is also high |
| t_op | input | 2 | 0 load, 1 store, 2 locked swap, 3 fence |
| t_addr | input | AW | Word address of the request |
| t_wdata | input | DW | Store data or swap value |
| t_rvalid | output | 1 | One-cycle strobe carrying load or swap result |
| t_rdata | output | DW | Result data |
| m_req_valid | output | 1 | Memory request valid |
| m_req_ready | input | 1 | Memory accepts request |
| m_req_write | output | 1 | 1 write, 0 read |
| m_req_addr | output | AW | Memory address |
| m_req_wdata | output | DW | Memory write data |
| m_lock | output | 1 | High across a locked swap's read and write |
| m_rsp_valid | input | 1 | Read data valid |
| m_rsp_data | input | DW | Read data |

## Verification
The bench targets multiple stores to one address followed by a load. A design that picked the oldest match, or read memory, would return stale data. Write acceptance is throttled so that the queue fills. A design that overflowed would drop or corrupt a store, which shows up as an out-of-order or wrong write. A design that stalled hit loads while full would hang. Fences and locked swaps are issued behind queued stores. A design that let them through early, or dropped the lock between read and write, would have the queue non-empty at acceptance or return a value that ignores the drained stores. A litmus sequence of stores followed by a load to another address checks that the load reaches memory while stores remain queued; a design holding loads behind the queue fails that check.

// File: rtl/tsb_pkg.sv
// Shared encodings for the ordered store queue.
// Assumes a two-bit thread opcode and one controller state register.
package tsb_pkg;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_STORE  = 2'd1,
        OP_LOCKED = 2'd2,
        OP_FENCE  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_LD_ISSUE = 3'd1,
        ST_LD_WAIT  = 3'd2,
        ST_LK_RD    = 3'd3,
        ST_LK_WAIT  = 3'd4,
        ST_LK_WR    = 3'd5
    } state_e;

endpackage

// File: rtl/tsb_queue.sv
// Circular store queue holding address/data pairs in issue order.
// Assumes DEPTH is a power of two, at least 2. The caller never pushes
// when full and never pops when empty. All entries are exposed for the
// forwarding search.
module tsb_queue #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count,
    output logic [PW-1:0] rd_ptr,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic [AW-1:0] ent_addr [DEPTH],
    output logic [DW-1:0] ent_data [DEPTH]
);

    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    logic [PW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= wr_q + PW'(1);
            if (pop)  rd_q <= rd_q + PW'(1);
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    // Entry storage, written at the tail.
    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_q] <= push_addr;
            data_q[wr_q] <= push_data;
        end
    end

    assign full      = (cnt_q == CW'(DEPTH));
    assign empty     = (cnt_q == '0);
    assign count     = cnt_q;
    assign rd_ptr    = rd_q;
    assign head_addr = addr_q[rd_q];
    assign head_data = data_q[rd_q];
    assign ent_addr  = addr_q;
    assign ent_data  = data_q;

endmodule

// File: rtl/tsb_forward.sv
// Store-to-load forwarding search over the live queue entries.
// Assumes entries are ordered oldest-first starting at rd_ptr. The match
// with the highest age index (the youngest store) supplies the data.
module tsb_forward #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic [PW-1:0] rd_ptr,
    input  logic [CW-1:0] count,
    input  logic [AW-1:0] ent_addr [DEPTH],
    input  logic [DW-1:0] ent_data [DEPTH],
    input  logic [AW-1:0] look_addr,
    output logic          hit,
    output logic [DW-1:0] hit_data
);

    logic [PW-1:0] slot   [DEPTH];
    logic          age_hit [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_age
        assign slot[g]    = rd_ptr + PW'(g);
        assign age_hit[g] = (CW'(g) < count) && (ent_addr[slot[g]] == look_addr);
    end

    // Youngest matching entry wins: later ages overwrite earlier ones.
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (age_hit[i]) begin
                hit      = 1'b1;
                hit_data = ent_data[slot[i]];
            end
        end
    end

endmodule

// File: rtl/tsb_ctrl.sv
// Request sequencer: accepts thread requests, drains the queue and owns
// the memory port. Assumes memory answers reads in order with at least
// one cycle of latency, and gives no response to writes. Draining runs
// whenever the controller does not own the port. A write already offered
// is held until accepted.
module tsb_ctrl
    import tsb_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          t_valid,
    output logic          t_ready,
    input  logic [1:0]    t_op,
    input  logic [AW-1:0] t_addr,
    input  logic [DW-1:0] t_wdata,
    output logic          t_rvalid,
    output logic [DW-1:0] t_rdata,
    input  logic          fwd_hit,
    input  logic [DW-1:0] fwd_data,
    input  logic          q_full,
    input  logic          q_empty,
    input  logic [AW-1:0] q_head_addr,
    input  logic [DW-1:0] q_head_data,
    output logic          q_push,
    output logic          q_pop,
    output logic          m_req_valid,
    input  logic          m_req_ready,
    output logic          m_req_write,
    output logic [AW-1:0] m_req_addr,
    output logic [DW-1:0] m_req_wdata,
    output logic          m_lock,
    input  logic          m_rsp_valid,
    input  logic [DW-1:0] m_rsp_data
);

    state_e        state_q, state_d;
    logic          hold_q, hold_d;
    logic [AW-1:0] addr_q, addr_d;
    logic [DW-1:0] wdat_q, wdat_d;
    logic [DW-1:0] old_q, old_d;
    logic          rvalid_q, rvalid_d;
    logic [DW-1:0] rdata_q, rdata_d;
    op_e           op;
    logic          accept;
    logic          drain_valid;
    logic          own_valid, own_write;

    assign op = op_e'(t_op);

    // Which requests may be taken in the current state.
    always_comb begin
        t_ready = 1'b0;
        if (state_q == ST_IDLE) begin
            unique case (op)
                OP_LOAD:   t_ready = 1'b1;
                OP_STORE:  t_ready = !q_full;
                OP_LOCKED: t_ready = q_empty;
                OP_FENCE:  t_ready = q_empty;
                default:   t_ready = 1'b0;
            endcase
        end
    end

    assign accept      = t_valid && t_ready;
    assign q_push      = accept && (op == OP_STORE);
    assign drain_valid = !q_empty &&
                         (hold_q || state_q == ST_IDLE || state_q == ST_LD_WAIT);

    // Controller-owned memory request for loads and locked swaps.
    always_comb begin
        own_valid = 1'b0;
        own_write = 1'b0;
        unique case (state_q)
            ST_LD_ISSUE: own_valid = !hold_q;
            ST_LK_RD:    own_valid = 1'b1;
            ST_LK_WR: begin
                own_valid = 1'b1;
                own_write = 1'b1;
            end
            default: own_valid = 1'b0;
        endcase
    end

    // Memory port mux: a drain write and an owned request never overlap.
    always_comb begin
        m_req_valid = drain_valid || own_valid;
        if (drain_valid) begin
            m_req_write = 1'b1;
            m_req_addr  = q_head_addr;
            m_req_wdata = q_head_data;
        end else begin
            m_req_write = own_write;
            m_req_addr  = addr_q;
            m_req_wdata = wdat_q;
        end
    end

    assign q_pop  = drain_valid && m_req_ready;
    assign hold_d = drain_valid && !m_req_ready;
    assign m_lock = (state_q == ST_LK_RD) || (state_q == ST_LK_WAIT) ||
                    (state_q == ST_LK_WR);

    // Next-state and response selection.
    always_comb begin
        state_d  = state_q;
        addr_d   = addr_q;
        wdat_d   = wdat_q;
        old_d    = old_q;
        rvalid_d = 1'b0;
        rdata_d  = rdata_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && op == OP_LOAD) begin
                    if (fwd_hit) begin
                        rvalid_d = 1'b1;
                        rdata_d  = fwd_data;
                    end else begin
                        addr_d  = t_addr;
                        state_d = ST_LD_ISSUE;
                    end
                end else if (accept && op == OP_LOCKED) begin
                    addr_d  = t_addr;
                    wdat_d  = t_wdata;
                    state_d = ST_LK_RD;
                end
            end
            ST_LD_ISSUE: if (own_valid && m_req_ready) state_d = ST_LD_WAIT;
            ST_LD_WAIT: begin
                if (m_rsp_valid) begin
                    rvalid_d = 1'b1;
                    rdata_d  = m_rsp_data;
                    state_d  = ST_IDLE;
                end
            end
            ST_LK_RD: if (m_req_ready) state_d = ST_LK_WAIT;
            ST_LK_WAIT: begin
                if (m_rsp_valid) begin
                    old_d   = m_rsp_data;
                    state_d = ST_LK_WR;
                end
            end
            ST_LK_WR: begin
                if (m_req_ready) begin
                    rvalid_d = 1'b1;
                    rdata_d  = old_q;
                    state_d  = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Controller registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            hold_q   <= 1'b0;
            addr_q   <= '0;
            wdat_q   <= '0;
            old_q    <= '0;
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            state_q  <= state_d;
            hold_q   <= hold_d;
            addr_q   <= addr_d;
            wdat_q   <= wdat_d;
            old_q    <= old_d;
            rvalid_q <= rvalid_d;
            rdata_q  <= rdata_d;
        end
    end

    assign t_rvalid = rvalid_q;
    assign t_rdata  = rdata_q;

endmodule

// File: rtl/tso_store_buffer.sv
// Per-thread store buffer with store-to-load forwarding.
// Stores drain in order, and loads may pass older stores to other
// addresses. Fences and locked swaps wait for an empty queue. Assumes
// DEPTH is a power of two, at least 2.
module tso_store_buffer #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          t_valid,
    output logic          t_ready,
    input  logic [1:0]    t_op,
    input  logic [AW-1:0] t_addr,
    input  logic [DW-1:0] t_wdata,
    output logic          t_rvalid,
    output logic [DW-1:0] t_rdata,
    output logic          m_req_valid,
    input  logic          m_req_ready,
    output logic          m_req_write,
    output logic [AW-1:0] m_req_addr,
    output logic [DW-1:0] m_req_wdata,
    output logic          m_lock,
    input  logic          m_rsp_valid,
    input  logic [DW-1:0] m_rsp_data
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic          q_push, q_pop, q_full, q_empty;
    logic [CW-1:0] q_count;
    logic [PW-1:0] q_rd_ptr;
    logic [AW-1:0] q_head_addr;
    logic [DW-1:0] q_head_data;
    logic [AW-1:0] q_ent_addr [DEPTH];
    logic [DW-1:0] q_ent_data [DEPTH];
    logic          fwd_hit;
    logic [DW-1:0] fwd_data;

    tsb_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_addr (t_addr),
        .push_data (t_wdata),
        .pop       (q_pop),
        .full      (q_full),
        .empty     (q_empty),
        .count     (q_count),
        .rd_ptr    (q_rd_ptr),
        .head_addr (q_head_addr),
        .head_data (q_head_data),
        .ent_addr  (q_ent_addr),
        .ent_data  (q_ent_data)
    );

    tsb_forward #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_forward (
        .rd_ptr    (q_rd_ptr),
        .count     (q_count),
        .ent_addr  (q_ent_addr),
        .ent_data  (q_ent_data),
        .look_addr (t_addr),
        .hit       (fwd_hit),
        .hit_data  (fwd_data)
    );

    tsb_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .t_valid     (t_valid),
        .t_ready     (t_ready),
        .t_op        (t_op),
        .t_addr      (t_addr),
        .t_wdata     (t_wdata),
        .t_rvalid    (t_rvalid),
        .t_rdata     (t_rdata),
        .fwd_hit     (fwd_hit),
        .fwd_data    (fwd_data),
        .q_full      (q_full),
        .q_empty     (q_empty),
        .q_head_addr (q_head_addr),
        .q_head_data (q_head_data),
        .q_push      (q_push),
        .q_pop       (q_pop),
        .m_req_valid (m_req_valid),
        .m_req_ready (m_req_ready),
        .m_req_write (m_req_write),
        .m_req_addr  (m_req_addr),
        .m_req_wdata (m_req_wdata),
        .m_lock      (m_lock),
        .m_rsp_valid (m_rsp_valid),
        .m_rsp_data  (m_rsp_data)
    );

endmodule

// File: rtl/tsb_checker.sv
// Protocol and ordering properties for the store buffer, bound to the top.
// Assumes q_count is the queue occupancy seen inside the top.
module tsb_checker #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          t_valid,
    input logic          t_ready,
    input logic [1:0]    t_op,
    input logic          t_rvalid,
    input logic          m_req_valid,
    input logic          m_req_ready,
    input logic          m_req_write,
    input logic [AW-1:0] m_req_addr,
    input logic [DW-1:0] m_req_wdata,
    input logic          m_lock,
    input logic [CW-1:0] q_count
);

    // R5: occupancy never exceeds the configured depth.
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CW'(DEPTH));

    // R5: a full queue refuses stores.
    p_full_blocks_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == CW'(DEPTH) && t_valid && t_op == 2'd1) |-> !t_ready);

    // R9: an offered memory request holds until accepted.
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req_valid && !m_req_ready) |=>
        (m_req_valid && $stable(m_req_addr) && $stable(m_req_wdata) &&
         $stable(m_req_write)));

    // R7: a fence is only taken with an empty queue.
    p_fence_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (t_valid && t_ready && t_op == 2'd3) |-> (q_count == '0));

    // R8: a locked swap is only taken with an empty queue.
    p_lock_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (t_valid && t_ready && t_op == 2'd2) |-> (q_count == '0));

    // R8: the lock drops only after its write was accepted.
    p_lock_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(m_lock) |-> $past(m_req_valid && m_req_ready && m_req_write));

    // R10: no response or request is driven while reset is held.
    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |=> (!t_rvalid && !m_req_valid && !m_lock) || !rst_n);

endmodule

bind tso_store_buffer tsb_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .t_valid     (t_valid),
    .t_ready     (t_ready),
    .t_op        (t_op),
    .t_rvalid    (t_rvalid),
    .m_req_valid (m_req_valid),
    .m_req_ready (m_req_ready),
    .m_req_write (m_req_write),
    .m_req_addr  (m_req_addr),
    .m_req_wdata (m_req_wdata),
    .m_lock      (m_lock),
    .q_count     (q_count)
);

// File: tb/tso_store_buffer_test.sv
// Self-checking bench: behavioural store queue and memory model compared
// on every clock. Inputs change 1 ns after a rising edge; checks run on
// falling edges.
module tso_store_buffer_test;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        t_valid = 1'b0;
    logic        t_ready;
    logic [1:0]  t_op = 2'd0;
    logic [31:0] t_addr = '0;
    logic [31:0] t_wdata = '0;
    logic        t_rvalid;
    logic [31:0] t_rdata;
    logic        m_req_valid;
    logic        m_req_ready;
    logic        m_req_write;
    logic [31:0] m_req_addr;
    logic [31:0] m_req_wdata;
    logic        m_lock;
    logic        m_rsp_valid = 1'b0;
    logic [31:0] m_rsp_data = '0;

    logic        wr_gate = 1'b1;
    logic        rd_gate = 1'b1;
    int          gate_mode = 0;

    assign m_req_ready = m_req_write ? wr_gate : rd_gate;

    tso_store_buffer #(.DEPTH(DEPTH), .AW(32), .DW(32)) uut (
        .clk(clk), .rst_n(rst_n),
        .t_valid(t_valid), .t_ready(t_ready), .t_op(t_op),
        .t_addr(t_addr), .t_wdata(t_wdata),
        .t_rvalid(t_rvalid), .t_rdata(t_rdata),
        .m_req_valid(m_req_valid), .m_req_ready(m_req_ready),
        .m_req_write(m_req_write), .m_req_addr(m_req_addr),
        .m_req_wdata(m_req_wdata), .m_lock(m_lock),
        .m_rsp_valid(m_rsp_valid), .m_rsp_data(m_rsp_data)
    );

    always #2 clk = ~clk;

    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    logic [31:0] mem_m [16];
    logic [63:0] ref_q [$];
    logic [31:0] exp_q [$];
    string       tag_q [$];
    int          rsp_cnt = 0;
    logic [31:0] rsp_dat = '0;
    logic [31:0] pend_addr = '0;
    logic        pend_lock = 1'b0;
    logic [31:0] lk_new = '0;
    bit          hit_due = 0;
    bit          litmus_on = 0;
    int          stall_seen = 0;
    int          hit_full_seen = 0;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] wa(input int idx);
        return 32'h100 + 32'(idx) * 4;
    endfunction

    // Memory side: write gating pattern and read responses.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        unique case (gate_mode)
            0: wr_gate = 1'b1;
            1: wr_gate = (cyc % 8 == 0);
            2: wr_gate = 1'b0;
            default: wr_gate = (cyc % 3 != 0);
        endcase
        rd_gate = (gate_mode == 3) ? (cyc % 5 != 1) : 1'b1;
        m_rsp_valid = 1'b0;
        if (rsp_cnt > 0) begin
            rsp_cnt = rsp_cnt - 1;
            if (rsp_cnt == 0) begin
                m_rsp_valid = 1'b1;
                m_rsp_data  = rsp_dat;
            end
        end
    end

    // Reference model, evaluated before each rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (hit_due) begin
                check(t_rvalid, "R2 forward latency", 32'(t_rvalid), 32'd1);
                hit_due = 0;
            end
            if (t_rvalid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected response", t_rdata, 32'h0);
                end else begin
                    automatic logic [31:0] e = exp_q.pop_front();
                    automatic string tg = tag_q.pop_front();
                    check(t_rdata == e, tg, t_rdata, e);
                end
            end
            if (t_valid && t_op == 2'd1 && ref_q.size() == DEPTH) begin
                check(!t_ready, "R5 store while full", 32'(t_ready), 32'd0);
                stall_seen++;
            end
            // Thread-side acceptance.
            if (t_valid && t_ready) begin
                unique case (t_op)
                    2'd1: ref_q.push_back({t_addr, t_wdata});
                    2'd0: begin
                        automatic bit hit = 0;
                        automatic int n = 0;
                        automatic logic [31:0] v = mem_m[t_addr[5:2]];
                        foreach (ref_q[i]) if (ref_q[i][63:32] == t_addr) begin
                            hit = 1; n++; v = ref_q[i][31:0];
                        end
                        exp_q.push_back(v);
                        if (hit && ref_q.size() == DEPTH) begin
                            tag_q.push_back("R6 hit while full");
                            hit_full_seen++;
                        end else if (n > 1) tag_q.push_back("R3 youngest match");
                        else if (hit) tag_q.push_back("R2 forwarded data");
                        else tag_q.push_back("R4 memory load");
                        hit_due = hit;
                        pend_addr = t_addr;
                        pend_lock = 1'b0;
                    end
                    2'd2: begin
                        check(ref_q.size() == 0, "R8 swap with queue empty",
                              32'(ref_q.size()), 32'd0);
                        exp_q.push_back(mem_m[t_addr[5:2]]);
                        tag_q.push_back("R8 swap old value");
                        pend_addr = t_addr;
                        pend_lock = 1'b1;
                        lk_new = t_wdata;
                    end
                    default: check(ref_q.size() == 0, "R7 fence with queue empty",
                                   32'(ref_q.size()), 32'd0);
                endcase
            end
            // Memory-side acceptance.
            if (m_req_valid && m_req_ready) begin
                if (m_req_write && !m_lock) begin
                    if (ref_q.size() == 0) begin
                        check(1'b0, "R1 write with empty queue", m_req_addr, 32'h0);
                    end else begin
                        automatic logic [63:0] f = ref_q.pop_front();
                        check(m_req_addr == f[63:32] && m_req_wdata == f[31:0],
                              "R1 drain order", m_req_wdata, f[31:0]);
                        mem_m[m_req_addr[5:2]] = m_req_wdata;
                    end
                end else if (m_req_write) begin
                    check(pend_lock && m_req_addr == pend_addr && m_req_wdata == lk_new,
                          "R8 locked write", m_req_wdata, lk_new);
                    mem_m[m_req_addr[5:2]] = m_req_wdata;
                end else begin
                    check(m_req_addr == pend_addr && m_lock == pend_lock,
                          "R4 read address", m_req_addr, pend_addr);
                    if (litmus_on && !pend_lock) begin
                        check(ref_q.size() > 0, "R11 load passes queued stores",
                              32'(ref_q.size()), 32'd1);
                        litmus_on = 0;
                    end
                    rsp_cnt = 2;
                    rsp_dat = mem_m[m_req_addr[5:2]];
                end
            end
        end
    end

    task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d);
        t_valid = 1'b1;
        t_op    = op;
        t_addr  = a;
        t_wdata = d;
        forever begin
            @(negedge clk);
            if (t_ready) break;
        end
        @(posedge clk);
        #1;
        t_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        if (cyc == 60000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mem_m[i] = 32'hA000_0000 + 32'(i);
        repeat (3) @(negedge clk);
        check(!t_rvalid && !m_req_valid && !m_lock, "R10 reset state",
              {29'd0, t_rvalid, m_req_valid, m_lock}, 32'd0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        idle(2);

        // Same-address forwarding with writes blocked.
        gate_mode = 2;
        issue(2'd1, wa(1), 32'h11);
        issue(2'd1, wa(1), 32'h22);
        issue(2'd1, wa(2), 32'h33);
        issue(2'd0, wa(1), 32'h0);
        issue(2'd0, wa(2), 32'h0);
        idle(3);

        // Litmus: store then load to another address while writes trickle.
        gate_mode = 1;
        issue(2'd1, wa(3), 32'h44);
        issue(2'd1, wa(4), 32'h55);
        litmus_on = 1;
        issue(2'd0, wa(9), 32'h0);
        idle(6);
        check(litmus_on == 0, "R11 load reached memory", 32'(litmus_on), 32'd0);

        // Fill the queue, forward while full, then stall a store.
        gate_mode = 2;
        for (int k = 0; k < 16 && ref_q.size() < DEPTH; k++)
            issue(2'd1, wa(5 + (k % 3)), 32'h600 + 32'(k));
        issue(2'd0, wa(6), 32'h0);
        idle(2);
        check(hit_full_seen > 0, "R6 hit load taken while full", 32'(hit_full_seen), 32'd1);
        fork
            begin
                idle(6);
                gate_mode = 0;
            end
        join_none
        issue(2'd1, wa(7), 32'h777);
        check(stall_seen > 0, "R5 store stalled while full", 32'(stall_seen), 32'd1);
        idle(4);

        // Fence behind queued stores.
        gate_mode = 1;
        issue(2'd1, wa(8), 32'h88);
        issue(2'd1, wa(9), 32'h99);
        issue(2'd3, 32'h0, 32'h0);
        check(ref_q.size() == 0, "R7 queue drained at fence", 32'(ref_q.size()), 32'd0);

        // Locked swap behind queued stores.
        issue(2'd1, wa(10), 32'hAA);
        issue(2'd1, wa(10), 32'hAB);
        issue(2'd2, wa(10), 32'hCC);
        idle(8);
        gate_mode = 0;
        issue(2'd0, wa(10), 32'h0);
        idle(6);

        // Mixed traffic with throttled memory.
        gate_mode = 3;
        for (int n = 0; n < 400; n++) begin
            automatic int r = $urandom_range(0, 99);
            automatic logic [31:0] a = wa($urandom_range(0, 7));
            automatic logic [31:0] d = $urandom;
            if (r < 45)      issue(2'd0, a, 32'h0);
            else if (r < 85) issue(2'd1, a, d);
            else if (r < 92) issue(2'd2, a, d);
            else             issue(2'd3, 32'h0, 32'h0);
        end
        gate_mode = 0;
        idle(40);
        check(ref_q.size() == 0 && exp_q.size() == 0, "R1 all stores written",
              32'(ref_q.size()), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule